// File: doc/BRIEF.md
# Deblocking Edge Mask Decision Unit

This unit decides, for a single line of pixels that crosses a block boundary, whether a deblocking filter should run on that line and, if so, which one. Its inputs are eight samples on each side of the edge (p0..p7 going away from the edge on one side, q0..q7 on the other) at 10-bit or 12-bit precision. It also takes three 8-bit strength thresholds, a bit-depth select and a filter-width mode. From these it derives a filter-mask flag, an inner flatness flag, an outer flatness flag and a high-edge-variance flag.

The three 8-bit thresholds are for the edge step, the interior steps and the variance. Before any comparison they are rescaled to the sample precision. The unit then resolves the flags into three mutually exclusive enables: a narrow filter, an 8-tap filter and a 16-tap filter. The variance flag is also passed out, because the narrow filter needs it.

All results are registered, so they appear one clock after the inputs. The pixel arithmetic of the filters, sample fetch and any transposition are handled elsewhere.

Top module: `dbk_edge_decide`

## Requirements
- R1: Each threshold (edge `thr_e`, interior `thr_i`, variance `thr_h`) is shifted left by 2 when `depth_sel` is 0 (10-bit samples) and by 4 when `depth_sel` is 1 (12-bit samples) before it is compared. The flatness limit F is 4 at 10 bits and 16 at 12 bits.
- R2: The inner-flat flag is set only when every one of |p1−p0|, |p2−p0|, |p3−p0|, |q1−q0|, |q2−q0| and |q3−q0| is at most F.
- R3: The outer-flat flag is set only when every |pk−p0| and every |qk−q0|, for k from 4 to 7, is at most F.
- R4: The filter mask requires each neighbour step |p1−p0|, |p2−p1|, |p3−p2|, |q1−q0|, |q2−q1| and |q3−q2| to be at most the scaled interior threshold.
- R5: The filter mask also requires 2·|q0−p0| + (|q1−p1| >> 1) to be at most the scaled edge threshold. The sum is formed wide enough that 12-bit extremes do not wrap.
- R6: `hev` is 1 exactly when |p1−p0| or |q1−q0| exceeds the scaled variance threshold. It does not depend on the mask or on the width mode.
- R7: With `width_sel` = 2'b10 (16-wide mode), the 16-tap enable is mask & inner-flat & outer-flat, the 8-tap enable is mask & inner-flat & !outer-flat, and the narrow enable is mask & !inner-flat.
- R8: With `width_sel` = 2'b01 (8-wide mode), the 8-tap enable is mask & inner-flat, the narrow enable is mask & !inner-flat, and the 16-tap enable is 0.
- R9: With `width_sel` = 2'b00 or 2'b11 (4-wide mode), the narrow enable equals the mask and the other two enables are 0.
- R10: At most one of the three enables is 1 in any cycle.
- R11: The outputs are registered and show the inputs of the previous clock edge. A synchronous active-low reset clears all four outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| px_p | input | 8*SAMPLE_W | Samples p0..p7, p0 in the lowest SAMPLE_W bits |
| px_q | input | 8*SAMPLE_W | Samples q0..q7, q0 in the lowest SAMPLE_W bits |
| thr_e | input | THR_W | Edge-step threshold, unscaled |
| thr_i | input | THR_W | Interior-step threshold, unscaled |
| thr_h | input | THR_W | Variance threshold, unscaled |
| depth_sel | input | 1 | 0: 10-bit samples, 1: 12-bit samples |
| width_sel | input | 2 | 00/11: 4-wide, 01: 8-wide, 10: 16-wide |
| en_narrow | output | 1 | Narrow filter enable |
| en_mid | output | 1 | 8-tap filter enable |
| en_wide | output | 1 | 16-tap filter enable |
| hev | output | 1 | High edge variance flag |

## Verification
The bench moves each of the sixteen samples, one at a time, through a band of offsets around a flat line. It does this in every width mode and at both depths, so every flatness and step comparison is hit exactly at its limit: a comparison using < instead of ≤ would flip the enables at an offset of exactly F or exactly the interior threshold. A separate grid over |q0−p0| and |q1−p1| tests the edge metric. A design that dropped the halving, the doubling or the sign of a difference would disagree along that grid's boundary. Threshold sweeps at both depths expose a shift by the wrong amount. Directed 12-bit extremes catch a metric that wraps and wrongly enables filtering across a full-scale step.

// File: rtl/dbk_pkg.sv
// Shared types for the deblocking edge decision unit.
// Assumes the width-mode code is two bits wide; code 3 is treated as 4-wide.
package dbk_pkg;

    // Filter width mode carried on width_sel
    typedef enum logic [1:0] {
        WMODE_4   = 2'b00,
        WMODE_8   = 2'b01,
        WMODE_16  = 2'b10,
        WMODE_4B  = 2'b11
    } wmode_e;

    // Decision flags gathered before the width resolution
    typedef struct packed {
        logic fm;
        logic flat_in;
        logic flat_out;
        logic hev;
    } edge_flags_t;

endpackage

// File: rtl/dbk_absdiff.sv
// Absolute difference of two unsigned samples.
// Forms the difference one bit wider and signed, so no input pair can overflow;
// the magnitude always fits back into W bits.
module dbk_absdiff #(
    parameter int W = 12
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag
);

    logic signed [W:0] diff;

    // Signed difference, then fold the sign away
    always_comb begin
        diff = $signed({1'b0, a}) - $signed({1'b0, b});
        if (diff[W]) begin
            mag = W'(-diff);
        end else begin
            mag = W'(diff);
        end
    end

endmodule

// File: rtl/dbk_thr_scale.sv
// Rescales the 8-bit strength thresholds to the sample precision and makes
// the flatness limit. Assumes exactly two supported depths: low and high.
module dbk_thr_scale #(
    parameter int THR_W    = 8,
    parameter int SHIFT_LO = 2,
    parameter int SHIFT_HI = 4,
    parameter int SC_W     = THR_W + SHIFT_HI
) (
    input  logic [THR_W-1:0] thr_e,
    input  logic [THR_W-1:0] thr_i,
    input  logic [THR_W-1:0] thr_h,
    input  logic             depth_sel,
    output logic [SC_W-1:0]  e_sc,
    output logic [SC_W-1:0]  i_sc,
    output logic [SC_W-1:0]  h_sc,
    output logic [SC_W-1:0]  f_sc
);

    localparam logic [SC_W-1:0] ONE = SC_W'(1);

    // Shift each threshold by the amount the selected depth calls for
    always_comb begin
        if (depth_sel) begin
            e_sc = SC_W'(thr_e) << SHIFT_HI;
            i_sc = SC_W'(thr_i) << SHIFT_HI;
            h_sc = SC_W'(thr_h) << SHIFT_HI;
            f_sc = ONE << SHIFT_HI;
        end else begin
            e_sc = SC_W'(thr_e) << SHIFT_LO;
            i_sc = SC_W'(thr_i) << SHIFT_LO;
            h_sc = SC_W'(thr_h) << SHIFT_LO;
            f_sc = ONE << SHIFT_LO;
        end
    end

endmodule

// File: rtl/dbk_side_flags.sv
// Flags for one side of the edge (either p or q). Sample 0 is the one next
// to the edge. Produces that side's share of the inner-flat, outer-flat,
// step-mask and variance conditions. Thresholds arrive already scaled.
module dbk_side_flags #(
    parameter int W  = 12,
    parameter int TW = 12
) (
    input  logic [7:0][W-1:0] s,
    input  logic [TW-1:0]     i_sc,
    input  logic [TW-1:0]     f_sc,
    input  logic [TW-1:0]     h_sc,
    output logic              flat_in,
    output logic              flat_out,
    output logic              steps_ok,
    output logic              hev_side
);

    localparam int CW = (W > TW) ? W : TW;

    logic [7:1][W-1:0] to_base;
    logic [3:1][W-1:0] step;

    // Distance of every sample from the sample next to the edge
    for (genvar k = 1; k < 8; k++) begin : g_base
        dbk_absdiff #(.W(W)) u_base (
            .a   (s[k]),
            .b   (s[0]),
            .mag (to_base[k])
        );
    end

    assign step[1] = to_base[1];

    // Steps between neighbouring interior samples
    for (genvar k = 2; k < 4; k++) begin : g_step
        dbk_absdiff #(.W(W)) u_step (
            .a   (s[k]),
            .b   (s[k-1]),
            .mag (step[k])
        );
    end

    // Compare the distances against the flatness limit (inner: 1..3, outer: 4..7)
    always_comb begin
        flat_in  = 1'b1;
        flat_out = 1'b1;
        for (int k = 1; k < 4; k++) begin
            if (CW'(to_base[k]) > CW'(f_sc)) flat_in = 1'b0;
        end
        for (int k = 4; k < 8; k++) begin
            if (CW'(to_base[k]) > CW'(f_sc)) flat_out = 1'b0;
        end
    end

    // Compare the interior steps against the interior threshold
    always_comb begin
        steps_ok = 1'b1;
        for (int k = 1; k < 4; k++) begin
            if (CW'(step[k]) > CW'(i_sc)) steps_ok = 1'b0;
        end
    end

    // Variance test on the step next to the edge
    always_comb begin
        hev_side = CW'(step[1]) > CW'(h_sc);
    end

endmodule

// File: rtl/dbk_mask_select.sv
// Resolves the decision flags into three mutually exclusive filter enables
// for the selected width mode. Purely combinational.
module dbk_mask_select
    import dbk_pkg::*;
(
    input  edge_flags_t flags,
    input  wmode_e      mode,
    output logic        narrow,
    output logic        mid,
    output logic        wide
);

    // Width-mode dependent selection; nothing is enabled without the mask
    always_comb begin
        narrow = 1'b0;
        mid    = 1'b0;
        wide   = 1'b0;
        case (mode)
            WMODE_16: begin
                wide   = flags.fm &  flags.flat_in &  flags.flat_out;
                mid    = flags.fm &  flags.flat_in & ~flags.flat_out;
                narrow = flags.fm & ~flags.flat_in;
            end
            WMODE_8: begin
                mid    = flags.fm &  flags.flat_in;
                narrow = flags.fm & ~flags.flat_in;
            end
            default: begin
                narrow = flags.fm;
            end
        endcase
    end

endmodule

// File: rtl/dbk_edge_decide.sv
// Deblocking edge decision unit, top level.
// Takes one line of sixteen samples across an edge together with the strength
// thresholds, and registers the filter enables and the variance flag. Samples
// narrower than SAMPLE_W must be zero-extended by the caller.
module dbk_edge_decide
    import dbk_pkg::*;
#(
    parameter int SAMPLE_W = 12,
    parameter int THR_W    = 8,
    parameter int SHIFT_LO = 2,
    parameter int SHIFT_HI = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [8*SAMPLE_W-1:0] px_p,
    input  logic [8*SAMPLE_W-1:0] px_q,
    input  logic [THR_W-1:0]      thr_e,
    input  logic [THR_W-1:0]      thr_i,
    input  logic [THR_W-1:0]      thr_h,
    input  logic                  depth_sel,
    input  logic [1:0]            width_sel,
    output logic                  en_narrow,
    output logic                  en_mid,
    output logic                  en_wide,
    output logic                  hev
);

    localparam int SC_W = THR_W + SHIFT_HI;
    localparam int MW   = SAMPLE_W + 2;
    localparam int MCW  = (MW > SC_W) ? MW : SC_W;

    logic [1:0][7:0][SAMPLE_W-1:0] side_px;
    logic [SC_W-1:0] e_sc, i_sc, h_sc, f_sc;
    logic [1:0] side_flat_in, side_flat_out, side_steps, side_hev;
    logic [SAMPLE_W-1:0] d_edge, d_outer;
    logic [MW-1:0]       metric;
    logic                edge_ok;
    edge_flags_t         flags;
    logic                nx_narrow, nx_mid, nx_wide;

    assign side_px[0] = px_p;
    assign side_px[1] = px_q;

    dbk_thr_scale #(
        .THR_W    (THR_W),
        .SHIFT_LO (SHIFT_LO),
        .SHIFT_HI (SHIFT_HI),
        .SC_W     (SC_W)
    ) u_scale (
        .thr_e     (thr_e),
        .thr_i     (thr_i),
        .thr_h     (thr_h),
        .depth_sel (depth_sel),
        .e_sc      (e_sc),
        .i_sc      (i_sc),
        .h_sc      (h_sc),
        .f_sc      (f_sc)
    );

    // One flag unit per side of the edge
    for (genvar g = 0; g < 2; g++) begin : g_side
        dbk_side_flags #(.W(SAMPLE_W), .TW(SC_W)) u_side (
            .s        (side_px[g]),
            .i_sc     (i_sc),
            .f_sc     (f_sc),
            .h_sc     (h_sc),
            .flat_in  (side_flat_in[g]),
            .flat_out (side_flat_out[g]),
            .steps_ok (side_steps[g]),
            .hev_side (side_hev[g])
        );
    end

    dbk_absdiff #(.W(SAMPLE_W)) u_edge (
        .a   (side_px[1][0]),
        .b   (side_px[0][0]),
        .mag (d_edge)
    );

    dbk_absdiff #(.W(SAMPLE_W)) u_outer (
        .a   (side_px[1][1]),
        .b   (side_px[0][1]),
        .mag (d_outer)
    );

    // Cross-edge metric, two bits wider than a sample so it cannot wrap
    always_comb begin
        metric  = (MW'(d_edge) << 1) + MW'(d_outer >> 1);
        edge_ok = MCW'(metric) <= MCW'(e_sc);
    end

    // Merge the per-side results into the edge-wide flags
    always_comb begin
        flags.fm       = edge_ok & (&side_steps);
        flags.flat_in  = &side_flat_in;
        flags.flat_out = &side_flat_out;
        flags.hev      = |side_hev;
    end

    dbk_mask_select u_select (
        .flags  (flags),
        .mode   (wmode_e'(width_sel)),
        .narrow (nx_narrow),
        .mid    (nx_mid),
        .wide   (nx_wide)
    );

    // Output register with synchronous active-low clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_narrow <= 1'b0;
            en_mid    <= 1'b0;
            en_wide   <= 1'b0;
            hev       <= 1'b0;
        end else begin
            en_narrow <= nx_narrow;
            en_mid    <= nx_mid;
            en_wide   <= nx_wide;
            hev       <= flags.hev;
        end
    end

endmodule

// File: rtl/dbk_edge_decide_chk.sv
// Property checker for dbk_edge_decide, attached by bind below.
// Relates the registered outputs to the port values of the previous edge.
module dbk_edge_decide_chk #(
    parameter int W     = 12,
    parameter int THR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [W-1:0]     p0,
    input logic [W-1:0]     p1,
    input logic [W-1:0]     q0,
    input logic [W-1:0]     q1,
    input logic [THR_W-1:0] thr_e,
    input logic [1:0]       width_sel,
    input logic             en_narrow,
    input logic             en_mid,
    input logic             en_wide,
    input logic             hev
);

    logic armed;

    // Marks that the previous edge saw reset released
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R10: enables never overlap
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_narrow, en_mid, en_wide}));

    // R9: 4-wide codes never produce the 8-tap or 16-tap enable
    p_width4_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(width_sel == 2'b00 || width_sel == 2'b11) |-> !en_mid && !en_wide);

    // R8: 8-wide mode never produces the 16-tap enable
    p_width8_r8: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(width_sel == 2'b01) |-> !en_wide);

    // R5: a zero edge threshold with any step across the edge blocks filtering
    p_zero_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(thr_e == '0 && p0 != q0) |-> !(en_narrow || en_mid || en_wide));

    // R6: no step next to the edge on either side means no variance flag
    p_hev_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(p1 == p0 && q1 == q0) |-> !hev);

endmodule

bind dbk_edge_decide dbk_edge_decide_chk #(.W(SAMPLE_W), .THR_W(THR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .p0        (px_p[SAMPLE_W-1:0]),
    .p1        (px_p[2*SAMPLE_W-1:SAMPLE_W]),
    .q0        (px_q[SAMPLE_W-1:0]),
    .q1        (px_q[2*SAMPLE_W-1:SAMPLE_W]),
    .thr_e     (thr_e),
    .width_sel (width_sel),
    .en_narrow (en_narrow),
    .en_mid    (en_mid),
    .en_wide   (en_wide),
    .hev       (hev)
);

// File: tb/dbk_edge_decide_test.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps sample offsets, the edge-metric grid and the
// thresholds, and compares against an arithmetic model of the requirements.
module dbk_edge_decide_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] px_p = '0;
    logic [95:0] px_q = '0;
    logic [7:0]  thr_e = '0, thr_i = '0, thr_h = '0;
    logic        depth_sel = 1'b0;
    logic [1:0]  width_sel = 2'b00;
    logic        en_narrow, en_mid, en_wide, hev;

    int errs = 0;
    int checks = 0;
    int vp[8];
    int vq[8];
    int ve, vi, vh, vdep, vw;

    always #4 clk = ~clk;

    dbk_edge_decide uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .px_p      (px_p),
        .px_q      (px_q),
        .thr_e     (thr_e),
        .thr_i     (thr_i),
        .thr_h     (thr_h),
        .depth_sel (depth_sel),
        .width_sel (width_sel),
        .en_narrow (en_narrow),
        .en_mid    (en_mid),
        .en_wide   (en_wide),
        .hev       (hev)
    );

    function automatic int iabs(input int x);
        return (x < 0) ? -x : x;
    endfunction

    // Model: returns {narrow, mid, wide, hev} from the requirement formulas
    function automatic logic [3:0] model();
        int sh, e, i, h, f;
        logic fi, fo, fm, hv, nar, mid, wid;
        sh = (vdep != 0) ? 4 : 2;
        e = ve << sh; i = vi << sh; h = vh << sh; f = 1 << sh;
        fi = 1'b1; fo = 1'b1; fm = 1'b1;
        for (int k = 1; k < 4; k++) begin
            if (iabs(vp[k] - vp[0]) > f || iabs(vq[k] - vq[0]) > f) fi = 1'b0;
            if (iabs(vp[k] - vp[k-1]) > i || iabs(vq[k] - vq[k-1]) > i) fm = 1'b0;
        end
        for (int k = 4; k < 8; k++) begin
            if (iabs(vp[k] - vp[0]) > f || iabs(vq[k] - vq[0]) > f) fo = 1'b0;
        end
        if (2 * iabs(vq[0] - vp[0]) + (iabs(vq[1] - vp[1]) >> 1) > e) fm = 1'b0;
        hv = (iabs(vp[1] - vp[0]) > h) || (iabs(vq[1] - vq[0]) > h);
        nar = 1'b0; mid = 1'b0; wid = 1'b0;
        if (vw == 2) begin
            wid = fm & fi & fo; mid = fm & fi & ~fo; nar = fm & ~fi;
        end else if (vw == 1) begin
            mid = fm & fi; nar = fm & ~fi;
        end else begin
            nar = fm;
        end
        return {nar, mid, wid, hv};
    endfunction

    task automatic chk(input string tag, input string name, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s %s: got %0b expected %0b (w=%0d dep=%0d e=%0d i=%0d h=%0d)",
                     tag, name, got, exp, vw, vdep, ve, vi, vh);
        end
    endtask

    task automatic set_flat(input int base);
        for (int k = 0; k < 8; k++) begin
            vp[k] = base;
            vq[k] = base;
        end
    endtask

    // Drive one vector after a falling edge, sample after the next falling edge
    task automatic apply(input string tag);
        logic [3:0] exp;
        for (int k = 0; k < 8; k++) begin
            px_p[k*12 +: 12] = vp[k][11:0];
            px_q[k*12 +: 12] = vq[k][11:0];
        end
        thr_e = ve[7:0]; thr_i = vi[7:0]; thr_h = vh[7:0];
        depth_sel = vdep[0];
        width_sel = vw[1:0];
        exp = model();
        @(posedge clk);
        @(negedge clk);
        chk(tag, "narrow(R7/R8/R9)", en_narrow, exp[3]);
        chk(tag, "mid(R7/R8)", en_mid, exp[2]);
        chk(tag, "wide(R7)", en_wide, exp[1]);
        chk(tag, "hev(R6)", hev, exp[0]);
        chk("R10", "at-most-one-enable", ($countones({en_narrow, en_mid, en_wide}) <= 1), 1'b1);
    endtask

    initial begin
        // R11: reset clears all outputs
        vw = 0; vdep = 0; ve = 0; vi = 0; vh = 0;
        set_flat(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11", "reset narrow", en_narrow, 1'b0);
        chk("R11", "reset mid", en_mid, 1'b0);
        chk("R11", "reset wide", en_wide, 1'b0);
        chk("R11", "reset hev", hev, 1'b0);
        rst_n = 1'b1;

        // R2 R3 R4 R7 R8 R9: move one sample at a time around a flat line
        for (int w = 0; w < 4; w++) begin
            for (int dep = 0; dep < 2; dep++) begin
                for (int k = 0; k < 16; k++) begin
                    for (int d = -60; d <= 60; d++) begin
                        vw = w; vdep = dep; ve = 40; vi = 3; vh = 2;
                        set_flat(512);
                        if (k < 8) vp[k] = 512 + d;
                        else       vq[k-8] = 512 + d;
                        apply("R2,R3,R4,R7,R8,R9 sample sweep");
                    end
                end
            end
        end

        // R5: grid over the cross-edge and outer differences
        for (int dep = 0; dep < 2; dep++) begin
            for (int a = -25; a <= 25; a++) begin
                for (int b = -50; b <= 50; b++) begin
                    vw = 0; vdep = dep; vi = 255; vh = 255;
                    ve = (dep != 0) ? 3 : 10;
                    set_flat(512);
                    vp[0] = 512 + a;
                    vq[1] = 512 + b;
                    apply("R5 edge metric grid");
                end
            end
        end

        // R1 R6: edge and variance threshold scaling at both depths
        for (int dep = 0; dep < 2; dep++) begin
            for (int t = 0; t < 256; t++) begin
                vw = 0; vdep = dep; vi = 255; ve = t; vh = t % 8;
                set_flat(1000);
                for (int k = 0; k < 8; k++) vq[k] = 1037;
                vq[1] = 1046;
                apply("R1,R6 threshold scaling");
            end
        end

        // R1 R4: interior threshold scaling on the q3-q2 step
        for (int dep = 0; dep < 2; dep++) begin
            for (int t = 0; t <= 20; t++) begin
                vw = 0; vdep = dep; ve = 255; vh = 255; vi = t;
                set_flat(700);
                vq[3] = 700 + ((dep != 0) ? 81 : 21);
                apply("R1,R4 interior scaling");
            end
        end

        // R5: 12-bit extremes must not wrap the metric
        vw = 2; vdep = 1; ve = 255; vi = 255; vh = 255;
        set_flat(0);
        for (int k = 0; k < 8; k++) vq[k] = 4095;
        apply("R5 full-scale step");
        vq[0] = 2040; vq[1] = 2040; set_flat(0);
        for (int k = 0; k < 8; k++) vq[k] = 2040;
        apply("R5 near-limit step");
        // R2 R3: flat lines at both ends of the range
        set_flat(4095); apply("R2,R3 flat top");
        set_flat(0);    apply("R2,R3 flat bottom");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule